// File: doc/BRIEF.md
# Three-Wire Serial Register Port

This block is the slave side of a three-wire control port that gives a host access to a small bank of byte registers. The host drives an active-low select, a serial clock and a shared data line. Each transaction sends one direction flag, a 7-bit register address and one data byte, most significant bit first. A write frame stores the byte in the bank. A read frame makes the block take over the data line for the second half of the frame and return the addressed byte.

All three host pins are slow compared with the system clock. They pass through synchronizer chains, and the block detects serial-clock edges in the system clock domain. The shared line is exposed as a separate input, output and output-enable, which the pad ring joins into one bidirectional pin.

Only 24 addresses hold storage. They sit in three windows: 0x00–0x11, 0x20–0x24 and 0x30. Returning data on reads requires an enable bit inside the bank. An active-low power-down input clears the whole bank.

Top module: `twr_slave`

## Requirements
- R1: A frame is the direction flag, then address bits A6 down to A0, then data bits D7 down to D0. Every host bit is taken on a rising serial-clock edge while select is low.
- R2: Direction flag 1 means write. The byte is stored on the 16th rising edge of the frame, and only when the address lies in 0x00–0x11, 0x20–0x24 or 0x30. Writes to any other address are discarded.
- R3: If select rises before the 16th rising edge, the frame changes nothing. Edges after the 16th are ignored. The bit count restarts at each new select-low period.
- R4: In a read frame (direction flag 0) with reads enabled, the output enable rises after the 8th falling serial-clock edge. D7 is driven first, and each later falling edge advances one bit, through D0.
- R5: The output enable is low during the first 8 bits of every frame and throughout write frames. It is also low while select is high, and it drops once select rises.
- R6: Register 0x00 bit 0 is the read enable. While it is 0, a read frame never raises the output enable.
- R7: A read of an address outside the three storage windows returns 0x00.
- R8: While power-down is low, every register returns to 0x00, which also clears the read enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the host pins |
| pdn_n | input | 1 | Active-low power-down; resets the bank and the frame logic |
| cs_n | input | 1 | Active-low frame select from the host |
| sclk | input | 1 | Serial clock from the host |
| sdio_i | input | 1 | Data line as seen at the pad |
| sdio_o | output | 1 | Read data driven toward the pad |
| sdio_oe | output | 1 | High while the block drives the data line |

## Verification
A wrong bit count or a misaligned header latch shows up at the ports within one frame. Read data comes back rotated or taken from a neighbouring address, or the output enable rises a bit early or late, and both are visible on the next read. A corrupted bank entry stays hidden until that address is read, so the random phase reads back often and follows writes closely. A stuck output enable appears within a few system cycles after select rises, and the bench samples the enable there after every frame.

// File: rtl/twr_pkg.sv
package twr_pkg;
   localparam int ADDR_W     = 7;
   localparam int DATA_W     = 8;
   localparam int FRAME_BITS = 1 + ADDR_W + DATA_W;
   localparam int CNT_W      = $clog2(FRAME_BITS + 1);

   // storage windows, lowest first; the index order follows this list
   localparam int N_SPANS = 3;
   localparam logic [ADDR_W-1:0] SPAN_LO [N_SPANS] = '{7'h00, 7'h20, 7'h30};
   localparam logic [ADDR_W-1:0] SPAN_HI [N_SPANS] = '{7'h11, 7'h24, 7'h30};

   function automatic int count_regs();
      int n;
      n = 0;
      for (int s = 0; s < N_SPANS; s++)
         n += int'(SPAN_HI[s]) - int'(SPAN_LO[s]) + 1;
      return n;
   endfunction

   localparam int NUM_REGS = count_regs();
   localparam int IDX_W    = $clog2(NUM_REGS);

   function automatic logic addr_valid(input logic [ADDR_W-1:0] a);
      logic v;
      v = 1'b0;
      for (int s = 0; s < N_SPANS; s++)
         if (ADDR_W'(a - SPAN_LO[s]) <= ADDR_W'(SPAN_HI[s] - SPAN_LO[s]))
            v = 1'b1;
      return v;
   endfunction

   function automatic logic [IDX_W-1:0] addr_index(input logic [ADDR_W-1:0] a);
      int base;
      logic [IDX_W-1:0] r;
      base = 0;
      r    = '0;
      for (int s = 0; s < N_SPANS; s++) begin
         if (ADDR_W'(a - SPAN_LO[s]) <= ADDR_W'(SPAN_HI[s] - SPAN_LO[s]))
            r = IDX_W'(base + int'(ADDR_W'(a - SPAN_LO[s])));
         base += int'(SPAN_HI[s]) - int'(SPAN_LO[s]) + 1;
      end
      return r;
   endfunction
endpackage

// File: rtl/twr_sync.sv
module twr_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic pdn_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("twr_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge pdn_n) begin
      if (!pdn_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/twr_frame.sv
module twr_frame
   import twr_pkg::*;
(
   input  logic              clk,
   input  logic              pdn_n,
   input  logic              cs_s,
   input  logic              sclk_s,
   input  logic              sdi_s,
   input  logic              rd_en,
   input  logic [DATA_W-1:0] rd_data,
   output logic [ADDR_W-1:0] acc_addr,
   output logic              wr_stb,
   output logic [DATA_W-1:0] wr_data,
   output logic              sdo,
   output logic              sdo_oe
);
   localparam logic [CNT_W-1:0] HDR_END = CNT_W'(1 + ADDR_W);
   localparam logic [CNT_W-1:0] FRM_END = CNT_W'(FRAME_BITS);

   generate
      if (1 + ADDR_W != DATA_W) begin : g_bad_shape
         $error("twr_frame: header and data must have equal length");
      end
   endgenerate

   logic              sclk_d;
   logic              rise, fall;
   logic [CNT_W-1:0]  bit_cnt;
   logic [DATA_W-2:0] shreg;
   logic              is_wr;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] out_sh;
   logic              oe_q;

   assign rise = sclk_s & ~sclk_d;
   assign fall = ~sclk_s & sclk_d;

   always_ff @(posedge clk or negedge pdn_n) begin
      if (!pdn_n) begin
         sclk_d  <= 1'b0;
         bit_cnt <= '0;
         shreg   <= '0;
         is_wr   <= 1'b0;
         addr_q  <= '0;
         out_sh  <= '0;
         oe_q    <= 1'b0;
      end else begin
         sclk_d <= sclk_s;
         if (cs_s) begin
            bit_cnt <= '0;
            oe_q    <= 1'b0;
         end else begin
            if (rise && bit_cnt != FRM_END) begin
               bit_cnt <= bit_cnt + 1'b1;
               shreg   <= {shreg[DATA_W-3:0], sdi_s};
               if (bit_cnt == HDR_END - 1'b1) begin
                  is_wr  <= shreg[DATA_W-2];
                  addr_q <= {shreg[DATA_W-3:0], sdi_s};
               end
            end
            if (fall) begin
               if (bit_cnt == HDR_END && !is_wr && rd_en) begin
                  out_sh <= rd_data;
                  oe_q   <= 1'b1;
               end else if (oe_q && bit_cnt > HDR_END && bit_cnt < FRM_END) begin
                  out_sh <= {out_sh[DATA_W-2:0], 1'b0};
               end
            end
         end
      end
   end

   assign wr_stb   = rise && !cs_s && is_wr && (bit_cnt == FRM_END - 1'b1);
   assign wr_data  = {shreg, sdi_s};
   assign acc_addr = addr_q;
   assign sdo      = out_sh[DATA_W-1];
   assign sdo_oe   = oe_q;

   assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!pdn_n)
      bit_cnt <= FRM_END);
   assert_write_closes_R2: assert property (@(posedge clk) disable iff (!pdn_n)
      wr_stb |=> bit_cnt == FRM_END);
   assert_oe_start_R4: assert property (@(posedge clk) disable iff (!pdn_n)
      $rose(sdo_oe) |-> (bit_cnt == HDR_END && !is_wr));
   assert_oe_release_R5: assert property (@(posedge clk) disable iff (!pdn_n)
      cs_s |=> !sdo_oe);
   assert_oe_header_R5: assert property (@(posedge clk) disable iff (!pdn_n)
      bit_cnt < HDR_END |-> !sdo_oe);
   assert_oe_gated_R6: assert property (@(posedge clk) disable iff (!pdn_n)
      sdo_oe |-> rd_en);
endmodule

// File: rtl/twr_regs.sv
module twr_regs
   import twr_pkg::*;
#(
   parameter logic [ADDR_W-1:0] CTRL_ADDR   = 7'h00,
   parameter int                RDEN_BIT    = 0,
   parameter logic [DATA_W-1:0] REG_DEFAULT = '0
) (
   input  logic              clk,
   input  logic              pdn_n,
   input  logic              wr_stb,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_en
);
   localparam logic [IDX_W-1:0] CTRL_IDX = addr_index(CTRL_ADDR);

   logic [NUM_REGS-1:0][DATA_W-1:0] bank;
   logic             hit;
   logic [IDX_W-1:0] idx;

   assign hit = addr_valid(acc_addr);
   assign idx = addr_index(acc_addr);

   always_ff @(posedge clk or negedge pdn_n) begin
      if (!pdn_n) begin
         for (int i = 0; i < NUM_REGS; i++) bank[i] <= REG_DEFAULT;
      end else if (wr_stb && hit) begin
         for (int i = 0; i < NUM_REGS; i++)
            if (idx == IDX_W'(i)) bank[i] <= wr_data;
      end
   end

   assign rd_data = hit ? bank[idx] : '0;
   assign rd_en   = bank[CTRL_IDX][RDEN_BIT];

   assert_ctrl_update_R2: assert property (@(posedge clk) disable iff (!pdn_n)
      (wr_stb && acc_addr == CTRL_ADDR) |=> rd_en == $past(wr_data[RDEN_BIT]));
   assert_foreign_write_R2: assert property (@(posedge clk) disable iff (!pdn_n)
      (wr_stb && !hit) |=> $stable(rd_en));
endmodule

// File: rtl/twr_slave.sv
module twr_slave
   import twr_pkg::*;
#(
   parameter int                SYNC_STAGES = 2,
   parameter logic [ADDR_W-1:0] CTRL_ADDR   = 7'h00,
   parameter int                RDEN_BIT    = 0,
   parameter logic [DATA_W-1:0] REG_DEFAULT = 8'h00
) (
   input  logic clk,
   input  logic pdn_n,
   input  logic cs_n,
   input  logic sclk,
   input  logic sdio_i,
   output logic sdio_o,
   output logic sdio_oe
);
   localparam int N_PINS = 3;

   generate
      if (RDEN_BIT < 0 || RDEN_BIT >= DATA_W) begin : g_bad_bit
         $error("twr_slave: RDEN_BIT outside the data byte");
      end
      if (!addr_valid(CTRL_ADDR)) begin : g_bad_ctrl
         $error("twr_slave: CTRL_ADDR has no storage");
      end
   endgenerate

   logic [N_PINS-1:0] raw, synced;
   assign raw = {sdio_i, sclk, cs_n};

   for (genvar i = 0; i < N_PINS; i++) begin : g_sync
      twr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(i == 0)) u_sync (
         .clk  (clk),
         .pdn_n(pdn_n),
         .d    (raw[i]),
         .q    (synced[i])
      );
   end

   logic              rd_en, wr_stb;
   logic [ADDR_W-1:0] acc_addr;
   logic [DATA_W-1:0] rd_data, wr_data;

   twr_frame u_frame (
      .clk     (clk),
      .pdn_n   (pdn_n),
      .cs_s    (synced[0]),
      .sclk_s  (synced[1]),
      .sdi_s   (synced[2]),
      .rd_en   (rd_en),
      .rd_data (rd_data),
      .acc_addr(acc_addr),
      .wr_stb  (wr_stb),
      .wr_data (wr_data),
      .sdo     (sdio_o),
      .sdo_oe  (sdio_oe)
   );

   twr_regs #(
      .CTRL_ADDR  (CTRL_ADDR),
      .RDEN_BIT   (RDEN_BIT),
      .REG_DEFAULT(REG_DEFAULT)
   ) u_regs (
      .clk     (clk),
      .pdn_n   (pdn_n),
      .wr_stb  (wr_stb),
      .acc_addr(acc_addr),
      .wr_data (wr_data),
      .rd_data (rd_data),
      .rd_en   (rd_en)
   );
endmodule

// File: tb/twr_slave_bench.sv
`timescale 1ns/1ps
module twr_slave_bench;
   localparam int HALF = 12;

   logic clk = 1'b0;
   logic pdn_n = 1'b0;
   logic cs_n = 1'b1;
   logic sclk = 1'b0;
   logic sdio_i = 1'b0;
   logic sdio_o, sdio_oe;

   int n_checks = 0;
   int n_fails  = 0;
   logic [7:0] model [128];

   always #4 clk = ~clk;

   twr_slave u_twr_slave (
      .clk(clk), .pdn_n(pdn_n), .cs_n(cs_n), .sclk(sclk),
      .sdio_i(sdio_i), .sdio_o(sdio_o), .sdio_oe(sdio_oe)
   );

   function automatic bit readable(input logic [6:0] a);
      return (a <= 7'h11) || (a >= 7'h20 && a <= 7'h24) || (a == 7'h30);
   endfunction

   function automatic logic [7:0] expect_rd(input logic [6:0] a);
      return readable(a) ? model[a] : 8'h00;
   endfunction

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic frame(input bit rw, input logic [6:0] a, input logic [7:0] d, input int nbits);
      logic [15:0] bits;
      logic [7:0]  got;
      bit oe_hdr, oe_any, oe_all, exp_oe;
      bits   = {rw, a, d};
      got    = '0;
      oe_hdr = 0; oe_any = 0; oe_all = 1;
      exp_oe = !rw && model[0][0];
      cs_n = 1'b0;
      repeat (HALF) @(negedge clk);
      for (int b = 0; b < nbits; b++) begin
         sclk   = 1'b0;
         sdio_i = (b < 16) ? bits[15-b] : 1'($urandom);
         repeat (HALF) @(negedge clk);
         if (b >= 8 && b < 16) begin
            got[15-b] = sdio_o;
            if (sdio_oe) oe_any = 1; else oe_all = 0;
         end else if (b < 8 && sdio_oe) oe_hdr = 1;
         sclk = 1'b1;
         repeat (HALF) @(negedge clk);
      end
      sclk = 1'b0;
      repeat (HALF) @(negedge clk);
      cs_n = 1'b1;
      repeat (HALF) @(negedge clk);
      // R5: no drive during the header, and released after select rises
      check(!oe_hdr, "R5 header drive", oe_hdr, 0);
      check(!sdio_oe, "R5 release after select", sdio_oe, 0);
      if (rw) begin
         check(!oe_any, "R5 write frame drive", oe_any, 0);
         if (nbits >= 16 && readable(a)) model[a] = d;
      end else if (nbits >= 16) begin
         if (exp_oe) begin
            check(oe_all, "R4 enable over data half", oe_all, 1);
            check(got == expect_rd(a), readable(a) ? "R1 read data" : "R7 empty address",
                  got, expect_rd(a));
         end else begin
            check(!oe_any, "R6 read disabled", oe_any, 0);
         end
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_checks++;
      n_fails++;
      $display("FAIL watchdog actual=timeout expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      logic [6:0] edge_addr [10];
      void'($urandom(32'd1234));
      for (int i = 0; i < 128; i++) model[i] = 8'h00;
      repeat (10) @(negedge clk);
      check(!sdio_oe, "R8 reset enable low", sdio_oe, 0);
      pdn_n = 1'b1;
      repeat (10) @(negedge clk);

      // R6: read enable clear after reset
      frame(1'b0, 7'h00, 8'h00, 16);
      // R2: set read enable, then read it back
      frame(1'b1, 7'h00, 8'h01, 16);
      frame(1'b0, 7'h00, 8'h00, 16);

      // R2, R7: window boundaries
      edge_addr = '{7'h11, 7'h12, 7'h1F, 7'h20, 7'h24, 7'h25, 7'h30, 7'h31, 7'h4F, 7'h7F};
      foreach (edge_addr[k]) begin
         frame(1'b1, edge_addr[k], 8'hA0 ^ 8'(k * 37 + 5), 16);
         frame(1'b0, edge_addr[k], 8'h00, 16);
      end

      // R3: aborted write, then over-long write
      frame(1'b1, 7'h05, 8'h3C, 16);
      frame(1'b1, 7'h05, 8'hC3, 10);
      frame(1'b0, 7'h05, 8'h00, 16);
      frame(1'b1, 7'h06, 8'h5A, 21);
      frame(1'b0, 7'h06, 8'h00, 16);
      frame(1'b0, 7'h06, 8'h00, 20);

      // R1: walking patterns
      frame(1'b1, 7'h10, 8'h80, 16);
      frame(1'b0, 7'h10, 8'h00, 16);
      frame(1'b1, 7'h10, 8'h01, 16);
      frame(1'b0, 7'h10, 8'h00, 16);

      // random mix
      for (int n = 0; n < 70; n++) begin
         logic [6:0] a;
         logic [7:0] d;
         bit rw;
         a  = ($urandom % 2) ? 7'($urandom % 19) : 7'($urandom);
         d  = 8'($urandom);
         rw = 1'($urandom);
         if (a == 7'h00 && rw) d[0] = ($urandom % 4) != 0;
         frame(rw, a, d, 16);
         if (rw) frame(1'b0, a, 8'h00, 16);
      end

      // R8: power-down clears the bank
      frame(1'b1, 7'h00, 8'h01, 16);
      frame(1'b1, 7'h23, 8'hE7, 16);
      pdn_n = 1'b0;
      repeat (6) @(negedge clk);
      pdn_n = 1'b1;
      for (int i = 0; i < 128; i++) model[i] = 8'h00;
      repeat (6) @(negedge clk);
      frame(1'b0, 7'h23, 8'h00, 16);
      frame(1'b1, 7'h00, 8'h01, 16);
      frame(1'b0, 7'h23, 8'h00, 16);

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end
endmodule